// File: doc/BRIEF.md
# Multi-Match PWM Timer

The timer holds one shared up-counter and a set of match registers that shape several pulse outputs. The counter advances by one on each cycle in which the count-enable tick is high. After the tick on which the count equals the programmed limit, it returns to zero, so one period lasts limit+1 ticks. Each output has two match values. When the count equals the first value, the output goes high. When the count equals the second value, the output goes low.

Setting every rise value to zero gives edge-aligned PWM. A non-zero rise value moves the rising edge inside the period, which gives variable-phase PWM. Two outputs with equal widths and rise values a quarter period apart form a quadrature pair. Software loads the limit and the match values through a simple write port. Those values sit in holding registers and move to the active set only when the counter wraps, so a period never mixes old and new settings. A one-clock interrupt pulse marks each wrap.

Top module: `pwm_match_timer`

## Requirements
- R1: The counter resets to 0 with a limit of 0 and changes only on a tick. On a tick it increments, and after the tick at which it equals the active limit it returns to 0, so the period is limit+1 ticks.
- R2: `wrap_irq` is high for exactly the one clock that follows a tick taken while the count equals the active limit, and is low otherwise.
- R3: Take a tick at count c. In the following clock, an enabled output goes high if c equals its rise value and c does not equal its fall value.
- R4: Take a tick at count c. In the following clock, an enabled output goes low if c equals its fall value. If the rise and fall values are equal, the fall wins and the output stays low.
- R5: Edge-aligned mode uses a rise value of 0 and a fall value of W, with 0 < W <= limit. After each tick at count c, the output is high exactly when c < W.
- R6: Phase-shifted mode uses a rise value S greater than the fall value C. After each tick at count c, the output is high exactly when c >= S or c < C.
- R7: Writes to the limit and match registers go to holding registers. The active values change only on the tick that wraps the counter, and that tick is still judged against the old values.
- R8: A cleared enable bit drives its output low in the clock after the enable register is written, without waiting for a tick. After the bit is set again, the output stays low until a rise match.
- R9: Two channels with a width of half the period and rise values a quarter period apart give outputs that are a quarter period apart in phase.
- R10: Register map. Address 0 holds the limit. For channel k, address 1+2k holds the rise value and address 2+2k holds the fall value. Bits [3:0] of address 9 are the per-channel enables. A write takes effect on a clock with `wr_en` high.
- R11: After reset, all outputs are low, `wrap_irq` is low, all match values are 0 and all enables are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one count per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_out | output | 4 | PWM outputs, one per channel |
| wrap_irq | output | 1 | One-clock pulse on counter wrap |

## Verification
Two kinds of event can land on the same tick. The first is a wrap that swaps in new settings while the outgoing count still has to be judged against the old match values. The second is a rise match and a fall match on the same count. Both cases come up in the bench. It sweeps every pair of rise and fall values, equal pairs included, for several limits, and it rewrites the settings in the middle of a period. Every output and interrupt value is compared against a window formula and against a period count that the bench keeps itself.

// File: rtl/pwm_match_timer.sv
module pwm_match_timer #(
  parameter int CW  = 16,
  parameter int NCH = 4,
  parameter int AW  = $clog2(2*NCH+2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic [NCH-1:0] pwm_out,
  output logic          wrap_irq
);
  localparam int EN_ADDR = 2*NCH + 1;

  logic [CW-1:0]  cnt, lim_act, lim_nxt;
  logic [CW-1:0]  rise_act [NCH];
  logic [CW-1:0]  rise_nxt [NCH];
  logic [CW-1:0]  fall_act [NCH];
  logic [CW-1:0]  fall_nxt [NCH];
  logic [NCH-1:0] en_q, out_q;
  logic           wrap;

  assign wrap    = tick && (cnt == lim_act);
  assign pwm_out = out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim_nxt <= '0;
      en_q    <= '0;
      for (int k = 0; k < NCH; k++) begin
        rise_nxt[k] <= '0;
        fall_nxt[k] <= '0;
      end
    end else if (wr_en) begin
      if (wr_addr == AW'(0)) lim_nxt <= wr_data;
      if (wr_addr == AW'(EN_ADDR)) en_q <= wr_data[NCH-1:0];
      for (int k = 0; k < NCH; k++) begin
        if (wr_addr == AW'(1 + 2*k)) rise_nxt[k] <= wr_data;
        if (wr_addr == AW'(2 + 2*k)) fall_nxt[k] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      lim_act  <= '0;
      wrap_irq <= 1'b0;
      for (int k = 0; k < NCH; k++) begin
        rise_act[k] <= '0;
        fall_act[k] <= '0;
      end
    end else begin
      wrap_irq <= wrap;
      if (wrap) begin
        cnt     <= '0;
        lim_act <= lim_nxt;
        for (int k = 0; k < NCH; k++) begin
          rise_act[k] <= rise_nxt[k];
          fall_act[k] <= fall_nxt[k];
        end
      end else if (tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n)                       out_q[g] <= 1'b0;
      else if (!en_q[g])                out_q[g] <= 1'b0;
      else if (tick && cnt == fall_act[g]) out_q[g] <= 1'b0;
      else if (tick && cnt == rise_act[g]) out_q[g] <= 1'b1;
    end

    // R8
    disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[g] |=> !out_q[g]);
    // R4
    fall_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt == fall_act[g]) |=> !out_q[g]);
    // R3
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_q[g]) |-> $past(tick && en_q[g] && cnt == rise_act[g]));
  end

  // R1
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
  // R1
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt != lim_act) |=> cnt == $past(cnt) + 1'b1);
  // R2
  irq_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_irq |-> cnt == '0);
endmodule

// File: tb/tb_pwm_match_timer.sv
module tb_pwm_match_timer;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [3:0] wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic [3:0] pwm_out;
  logic wrap_irq;

  pwm_match_timer dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out), .wrap_irq(wrap_irq));

  always #4 clk = ~clk;

  int checks = 0, failures = 0;
  int exp_cnt = 0, exp_lim = 0, pend_lim = 0, last_c = 0;
  int ps[4], pc[4], as_[4], ac[4];
  bit [3:0] en = 0;
  bit do_chk = 0, wrapped = 0;
  string tag = "R3";

  task automatic chk(bit ok, string t, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  function automatic bit in_win(int c, int s, int f);
    if (s == f) return 0;
    if (s < f) return (c >= s && c < f);
    return (c >= s || c < f);
  endfunction

  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1; wr_addr = 4'(a); wr_data = 16'(d);
    @(negedge clk); wr_en = 0;
    if (a == 0) pend_lim = d;
    else if (a == 9) en = d[3:0];
    else if (a % 2 == 1) ps[(a-1)/2] = d;
    else pc[(a-2)/2] = d;
  endtask

  task automatic tk();
    bit [3:0] eo;
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    last_c = exp_cnt;
    wrapped = (exp_cnt == exp_lim);
    for (int k = 0; k < 4; k++) eo[k] = en[k] && in_win(last_c, as_[k], ac[k]);
    if (wrapped) begin
      exp_cnt = 0; exp_lim = pend_lim;
      for (int k = 0; k < 4; k++) begin as_[k] = ps[k]; ac[k] = pc[k]; end
    end else exp_cnt++;
    if (do_chk) begin
      chk(wrap_irq == wrapped, "R2", int'(wrap_irq), int'(wrapped));
      chk(pwm_out == eo, tag, int'(pwm_out), int'(eo));
    end
  endtask

  task automatic settle();
    do_chk = 0;
    do tk(); while (!wrapped);
    for (int i = 0; i <= exp_lim; i++) tk();
  endtask

  initial begin
    int lims[3] = '{3, 5, 7};
    bit [3:0] hold;
    for (int k = 0; k < 4; k++) begin ps[k] = 0; pc[k] = 0; as_[k] = 0; ac[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11
    chk(pwm_out == 0, "R11", int'(pwm_out), 0);
    chk(wrap_irq == 0, "R11", int'(wrap_irq), 0);

    // R10 address map exercised by all programming below; sweep covers R3 R4 R5 R6 R1
    for (int li = 0; li < 3; li++) begin
      int L = lims[li];
      wr(0, L); wr(9, 15);
      for (int s = 0; s <= L; s++)
        for (int c = 0; c <= L; c++) begin
          for (int k = 0; k < 4; k++) begin
            wr(1 + 2*k, (s + k) % (L + 1));
            wr(2 + 2*k, (c + k) % (L + 1));
          end
          settle();
          tag = (s == c) ? "R4" : (s == 0) ? "R5" : (s > c) ? "R6" : "R3";
          do_chk = 1;
          for (int i = 0; i <= L; i++) tk();
        end
    end

    // R9 quadrature pair
    wr(0, 7); wr(1, 0); wr(2, 4); wr(3, 2); wr(4, 6); wr(5, 0); wr(6, 0); wr(7, 0); wr(8, 0);
    settle();
    tag = "R9"; do_chk = 1;
    for (int i = 0; i < 8; i++) begin
      tk();
      chk(pwm_out[1] == in_win((last_c + 6) % 8, 0, 4), "R9", int'(pwm_out[1]),
          int'(in_win((last_c + 6) % 8, 0, 4)));
    end

    // R1 no tick, no motion
    hold = pwm_out;
    repeat (10) @(negedge clk);
    chk(pwm_out == hold && wrap_irq == 0, "R1", int'(pwm_out), int'(hold));
    tag = "R1";
    for (int i = 0; i < 8; i++) tk();

    // R7 mid-period rewrite
    wr(0, 7); wr(1, 1); wr(2, 5); wr(3, 0); wr(4, 0);
    settle();
    tag = "R7"; do_chk = 1;
    tk(); tk(); tk();
    wr(0, 3); wr(1, 0); wr(2, 2);
    for (int i = 0; i < 5 + 4 + 4; i++) tk();

    // R8 enable gating
    wr(0, 7); wr(5, 0); wr(6, 6);
    settle();
    tk(); tk(); tk();
    chk(pwm_out[2] == 1, "R8", int'(pwm_out[2]), 1);
    wr(9, 4'b1011);
    @(negedge clk);
    chk(pwm_out[2] == 0, "R8", int'(pwm_out[2]), 0);
    wr(9, 15);
    do_chk = 0; tk();
    chk(pwm_out[2] == 0, "R8", int'(pwm_out[2]), 0);
    while (exp_cnt != 0) tk();
    tk();
    chk(pwm_out[2] == 1, "R8", int'(pwm_out[2]), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule